// File: doc/BRIEF.md
# Dual-Bank Audio Frame Collector

This block gathers a stream of 24-bit signed audio samples, arriving about every 20.8 microseconds, into frames of 1024 samples. Each sample is narrowed to 16 bits as it is written. Two banks of storage alternate between roles. One bank takes new samples while the other holds the last complete frame for a downstream transform engine to read at random.

When the collecting bank takes its 1024th sample, the two banks trade places in that clock edge. The block then gives a one-cycle start pulse to the transform engine and names the bank now held for reading. The consumer reads through a simple address/data port with one cycle of latency, and signals with a done strobe when it has finished with a frame. If a new frame completes before that strobe, the block raises a sticky overrun flag. The swap still happens, so the input stream never stalls and no sample is dropped.

Top module: `audio_pingpong_buf`

## Requirements
- R1: After reset, `frame_ready` and `overrun` are 0 and `work_bank` is 1, so bank 0 is collecting. The fill position is 0.
- R2: Each stored value is bits [23:8] of the accepted input sample: plain truncation, with no rounding.
- R3: `frame_ready` is high for exactly one cycle. That cycle follows the clock edge that accepts the 1024th sample of a frame. Otherwise it stays low.
- R4: Samples presented while `in_valid` is low are not stored and do not advance the fill position.
- R5: `work_bank` (0 = bank 0, 1 = bank 1) changes value exactly when `frame_ready` is high and holds its value in all other cycles.
- R6: The k-th accepted sample of a frame (k = 0..1023) is stored at address k. One cycle after `rd_addr` is presented, `rd_data` shows the word at that address in the bank named by `work_bank`.
- R7: While the next frame is being collected, the contents of the working bank do not change.
- R8: If a frame completes while the previous frame has not been acknowledged by `rd_done`, then `overrun` goes to 1 in the same cycle as `frame_ready`. The banks still swap.
- R9: `overrun` stays at 1 until reset.
- R10: A `rd_done` in the same cycle as the frame-completing sample acknowledges the previous frame, so no overrun occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_sample` for one cycle |
| in_sample | input | 24 | Signed audio sample |
| frame_ready | output | 1 | One-cycle transform-start pulse on each swap |
| work_bank | output | 1 | Bank currently held for reading |
| rd_addr | input | 10 | Read address within the working bank |
| rd_data | output | 16 | Stored sample, one cycle after `rd_addr` |
| rd_done | input | 1 | Consumer has finished with the working frame |
| overrun | output | 1 | Sticky: a frame completed before the previous one was acknowledged |

## Verification
The stream is tested with random samples and random idle gaps during which the sample bus carries junk. This separates counting valid beats from counting cycles. Directed extremes (full-scale positive, full-scale negative, all-ones and low-byte-only values) separate truncation from rounding or from taking the wrong slice. The previous frame is read back in the middle of the next frame, which shows whether writes leak into the held bank. Five frames are then run with the acknowledge given early, given in the very cycle of the swap, or withheld, which tells a correct sticky overrun apart from one that misses the same-cycle case or clears itself.

// File: rtl/audio_pingpong_buf.sv
module audio_pingpong_buf #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_sample,
  output logic             frame_ready,
  output logic             work_bank,
  input  logic [AW-1:0]    rd_addr,
  output logic [OUT_W-1:0] rd_data,
  input  logic             rd_done,
  output logic             overrun
);

  logic [OUT_W-1:0] mem [0:2*DEPTH-1];
  logic [AW-1:0]    fill_ptr;
  logic             fill_bank;
  logic             pending;

  wire last_beat = in_valid && (fill_ptr == AW'(DEPTH - 1));

  assign work_bank = ~fill_bank;

  always_ff @(posedge clk) begin
    if (in_valid) mem[{fill_bank, fill_ptr}] <= in_sample[IN_W-1 -: OUT_W];
    rd_data <= mem[{~fill_bank, rd_addr}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_ptr    <= '0;
      fill_bank   <= 1'b0;
      pending     <= 1'b0;
      overrun     <= 1'b0;
      frame_ready <= 1'b0;
    end else begin
      frame_ready <= last_beat;
      if (in_valid) fill_ptr <= last_beat ? '0 : fill_ptr + 1'b1;
      if (last_beat) begin
        fill_bank <= ~fill_bank;
        pending   <= 1'b1;
        if (pending && !rd_done) overrun <= 1'b1;
      end else if (rd_done) begin
        pending <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audio_pingpong_buf_chk.sv
module audio_pingpong_buf_chk #(
  parameter int DEPTH = 1024
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic frame_ready,
  input logic work_bank,
  input logic overrun
);

  localparam int CW = $clog2(DEPTH);
  logic [CW-1:0] beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beats <= '0;
    else if (in_valid) beats <= (beats == CW'(DEPTH - 1)) ? '0 : beats + 1'b1;
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |=> !frame_ready);

  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (beats == '0) && $past(in_valid));

  // R5
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (work_bank != $past(work_bank)));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ready |-> $stable(work_bank));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R8
  overrun_on_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> frame_ready);

endmodule

bind audio_pingpong_buf audio_pingpong_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .frame_ready(frame_ready), .work_bank(work_bank), .overrun(overrun)
);

// File: tb/sim_audio_pingpong_buf.sv
module sim_audio_pingpong_buf;
  localparam int N = 1024;

  logic clk = 0, rst_n = 0, in_valid = 0, rd_done = 0;
  logic [23:0] in_sample = '0;
  logic [9:0]  rd_addr = '0;
  logic        frame_ready, work_bank, overrun;
  logic [15:0] rd_data;

  int checks = 0, errors = 0;
  logic [15:0] exp_mem [0:1][0:N-1];
  int fb = 0;

  always #10 clk = ~clk;

  audio_pingpong_buf u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .frame_ready(frame_ready), .work_bank(work_bank), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_done(rd_done), .overrun(overrun)
  );

  function automatic logic [15:0] narrow(input logic [23:0] s);
    return s[23:8];
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input int a);
    rd_addr = 10'(a);
    tick();
    chk(req, 32'(rd_data), 32'(exp_mem[1-fb][a]));
  endtask

  task automatic run_frame(input bit directed, input bit done_last, input bit mid_read);
    for (int i = 0; i < N; i++) begin
      int gap = $urandom_range(0, 2);
      logic [23:0] d;
      for (int g = 0; g < gap; g++) begin
        in_valid = 0; in_sample = 24'($urandom);
        tick();
        chk("R4 no pulse on idle", 32'(frame_ready), 0);
      end
      if (mid_read && i == N/2)
        for (int r = 0; r < 16; r++) rd_check("R7 held bank during fill", $urandom_range(0, N-1));
      case (directed ? i : 99)
        0: d = 24'h7FFFFF;
        1: d = 24'h800000;
        2: d = 24'h0000FF;
        3: d = 24'hFFFFFF;
        4: d = 24'h1234FF;
        default: d = 24'($urandom);
      endcase
      exp_mem[fb][i] = narrow(d);
      in_valid = 1; in_sample = d; rd_done = done_last && (i == N-1);
      tick();
      in_valid = 0; rd_done = 0; in_sample = 24'($urandom);
      if (i < N-1) chk("R3 no early frame_ready", 32'(frame_ready), 0);
    end
    chk("R3 frame_ready on 1024th", 32'(frame_ready), 1);
    chk("R5 work_bank names filled bank", 32'(work_bank), 32'(fb));
    fb = 1 - fb;
    tick();
    chk("R3 single-cycle pulse", 32'(frame_ready), 0);
    chk("R5 work_bank holds", 32'(work_bank), 32'(1 - fb));
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < N; a++) rd_check(req, a);
  endtask

  initial begin
    void'($urandom(32'd7411));
    #1;
    chk("R1 frame_ready reset", 32'(frame_ready), 0);
    chk("R1 overrun reset", 32'(overrun), 0);
    chk("R1 work_bank reset", 32'(work_bank), 1);
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk("R1 work_bank after release", 32'(work_bank), 1);

    run_frame(1'b1, 1'b0, 1'b0);
    chk("R8 no overrun on first frame", 32'(overrun), 0);
    rd_check("R2 truncation 7FFFFF", 0);
    rd_check("R2 truncation 800000", 1);
    rd_check("R2 truncation 0000FF", 2);
    rd_check("R2 truncation FFFFFF", 3);
    rd_check("R2 truncation 1234FF", 4);
    read_all("R6 frame readback");

    rd_done = 1; tick(); rd_done = 0;
    run_frame(1'b0, 1'b0, 1'b1);
    chk("R8 acknowledged frame no overrun", 32'(overrun), 0);
    read_all("R6 second frame readback");

    run_frame(1'b1, 1'b1, 1'b0);
    chk("R10 same-cycle done no overrun", 32'(overrun), 0);

    run_frame(1'b0, 1'b0, 1'b0);
    chk("R8 overrun when unacknowledged", 32'(overrun), 1);
    read_all("R8 swap still happened");

    rd_done = 1; tick(); rd_done = 0;
    chk("R9 overrun sticky after done", 32'(overrun), 1);
    run_frame(1'b0, 1'b0, 1'b0);
    chk("R9 overrun sticky", 32'(overrun), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule